// File: doc/BRIEF.md
# Program Counter with Bus Drivers

This block holds the 16-bit fetch address of a small CPU with an 8-bit data path and a 16-bit address space. An asynchronous active-low reset clears it to 0x0000 at power-up, independently of the clock. On each rising clock edge it either loads a jump target from the address bus, advances by one, or holds its value. The count is built from four 4-bit counter slices. The lowest slice is always enabled. Each higher slice is enabled only by the terminal-count carry of the slice below it. A slice's carry is high only when its own enable is high and all of its bits are 1.

Three active-low enables give the value to the rest of the CPU. The word enable places all 16 bits on the address bus. The high-byte and low-byte enables place one byte on the 8-bit data bus. Each bus is an output stream with a valid flag and no ready. There is no back-pressure: a consumer samples the bus during the cycles in which valid is high, and the block never waits on it. When valid is low the bus is released, and the released value is all zeros. The load strobe, the count strobe and the enables are plain level controls, sampled at the rising clock edge or decoded combinationally.

Top module: `fetch_addr_counter`

## Requirements
- R1: While `rst_n` is low, the held value is 0x0000. Asserting `rst_n` clears the value at once, without waiting for a clock edge.
- R2: When `wr_n` is low at a rising clock edge, the value becomes `addr_in` after that edge.
- R3: When `wr_n` is high and `cnt_en` is high at a rising clock edge, the value increases by one.
- R4: When `wr_n` is low and `cnt_en` is high in the same cycle, the load wins and the value becomes `addr_in`.
- R5: Counting up from 0xFFFF gives 0x0000.
- R6: When `wr_n` is high and `cnt_en` is low, the value does not change across the edge.
- R7: Bits [15:4] change on a count edge only if bits [3:0] were 1111 before that edge. The same rule holds at every 4-bit boundary: a 4-bit group changes only when every lower group was all ones.
- R8: While `word_oe_n` is low, `addr_vld` is 1 and `addr_out` equals the value. While `word_oe_n` is high, `addr_vld` is 0 and `addr_out` is 0. The word enable works independently of the byte enables.
- R9: When `hi_oe_n` is low and `lo_oe_n` is high, `data_vld` is 1 and `data_out` equals bits [15:8] of the value.
- R10: When `lo_oe_n` is low and `hi_oe_n` is high, `data_vld` is 1 and `data_out` equals bits [7:0] of the value.
- R11: When both byte enables are high, or both are low (a clash), `data_vld` is 0 and `data_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| wr_n | input | 1 | Active-low load strobe; takes the jump target from `addr_in` |
| cnt_en | input | 1 | Active-high count strobe; advances the value by one |
| addr_in | input | 16 | Jump target read from the address bus |
| word_oe_n | input | 1 | Active-low enable that puts the full value on the address bus |
| hi_oe_n | input | 1 | Active-low enable that puts the high byte on the data bus |
| lo_oe_n | input | 1 | Active-low enable that puts the low byte on the data bus |
| addr_out | output | 16 | Address bus output; 0 when released |
| addr_vld | output | 1 | Address bus output is driven |
| data_out | output | 8 | Data bus byte output; 0 when released |
| data_vld | output | 1 | Data bus output is driven |

## Verification
The bench loads values just below the 4-bit, 8-bit, 12-bit and 16-bit boundaries (0x000F, 0x00FF, 0x0FFF, 0xFFFF) and then counts across them. A carry chain that used the top bit of a slice as its enable, or that left out a lower slice's enable, would move the upper groups too early or fail to move them at all. It drives load and count in the same cycle, which catches a design that gives count the priority. It drives both byte enables together, which catches a design that lets one byte win a clash. It also drops reset between clock edges, which catches a reset that only takes effect at an edge. Long random runs mix all strobes and enables, so that a swapped byte or a bus left driven after release shows up.

// File: rtl/fac_pkg.sv
package fac_pkg;

  // Which byte, if any, the data bus carries.
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_HI    = 2'd1,
    SRC_LO    = 2'd2,
    SRC_CLASH = 2'd3
  } byte_src_e;

  // Decode the two active-low byte enables.
  function automatic byte_src_e decode_src(input logic hi_n, input logic lo_n);
    case ({hi_n, lo_n})
      2'b01:   return SRC_HI;
      2'b10:   return SRC_LO;
      2'b00:   return SRC_CLASH;
      default: return SRC_NONE;
    endcase
  endfunction

endpackage

// File: rtl/fac_slice.sv
// One counter slice: synchronous load, count when enabled, asynchronous clear.
module fac_slice #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_n,
  input  logic         cnt_en,
  input  logic         ent,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (!load_n) begin
      q_r <= d;
    end else if (cnt_en && ent) begin
      q_r <= q_r + 1'b1;
    end
  end

  assign q = q_r;

endmodule

// File: rtl/fac_slice_chain.sv
// Counter slices joined by a chain of terminal-count enables.
module fac_slice_chain #(
  parameter int ADDR_W  = 16,
  parameter int SLICE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic              cnt_en,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] value
);

  localparam int NSLICE = ADDR_W / SLICE_W;

  // ent[k] enables slice k; the lowest slice is always enabled.
  logic [NSLICE-1:0] ent;
  assign ent[0] = 1'b1;

  for (genvar k = 0; k < NSLICE; k++) begin : g_slice
    fac_slice #(.W(SLICE_W)) u_slice (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_n (load_n),
      .cnt_en (cnt_en),
      .ent    (ent[k]),
      .d      (load_val[k*SLICE_W +: SLICE_W]),
      .q      (value[k*SLICE_W +: SLICE_W])
    );
    if (k < NSLICE - 1) begin : g_carry
      // Terminal-count carry: this slice is enabled and all its bits are 1.
      assign ent[k+1] = ent[k] & (&value[k*SLICE_W +: SLICE_W]);
    end
  end

endmodule

// File: rtl/fac_bus_sel.sv
// Output selection for the address bus and the data bus.
module fac_bus_sel
  import fac_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] value,
  input  logic              word_oe_n,
  input  logic              hi_oe_n,
  input  logic              lo_oe_n,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_vld,
  output logic [DATA_W-1:0] data_out,
  output logic              data_vld
);

  byte_src_e src;

  assign src      = decode_src(hi_oe_n, lo_oe_n);
  assign addr_vld = ~word_oe_n;
  assign addr_out = word_oe_n ? '0 : value;

  always_comb begin
    data_out = '0;
    data_vld = 1'b0;
    case (src)
      SRC_HI: begin
        data_out = value[ADDR_W-1 -: DATA_W];
        data_vld = 1'b1;
      end
      SRC_LO: begin
        data_out = value[DATA_W-1:0];
        data_vld = 1'b1;
      end
      default: begin
        data_out = '0;
        data_vld = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/fetch_addr_counter.sv
// Program counter with an address-bus word driver and data-bus byte drivers.
module fetch_addr_counter #(
  parameter int ADDR_W  = 16,
  parameter int SLICE_W = 4,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              cnt_en,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              word_oe_n,
  input  logic              hi_oe_n,
  input  logic              lo_oe_n,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_vld,
  output logic [DATA_W-1:0] data_out,
  output logic              data_vld
);

  logic [ADDR_W-1:0] pc_q;

  fac_slice_chain #(
    .ADDR_W  (ADDR_W),
    .SLICE_W (SLICE_W)
  ) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_n   (wr_n),
    .cnt_en   (cnt_en),
    .load_val (addr_in),
    .value    (pc_q)
  );

  fac_bus_sel #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_sel (
    .value     (pc_q),
    .word_oe_n (word_oe_n),
    .hi_oe_n   (hi_oe_n),
    .lo_oe_n   (lo_oe_n),
    .addr_out  (addr_out),
    .addr_vld  (addr_vld),
    .data_out  (data_out),
    .data_vld  (data_vld)
  );

endmodule

// File: rtl/fetch_addr_counter_chk.sv
// Property checker attached to the program counter.
module fetch_addr_counter_chk #(
  parameter int ADDR_W  = 16,
  parameter int SLICE_W = 4,
  parameter int DATA_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_n,
  input logic              cnt_en,
  input logic [ADDR_W-1:0] addr_in,
  input logic              word_oe_n,
  input logic              hi_oe_n,
  input logic              lo_oe_n,
  input logic [ADDR_W-1:0] addr_out,
  input logic              addr_vld,
  input logic [DATA_W-1:0] data_out,
  input logic              data_vld,
  input logic [ADDR_W-1:0] cur_q
);

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |=> cur_q == $past(addr_in));

  a_r3_count: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_n && cnt_en) |=> cur_q == ADDR_W'($past(cur_q) + 1'b1));

  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_n && cnt_en && cur_q == {ADDR_W{1'b1}}) |=> cur_q == '0);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_n && !cnt_en) |=> $stable(cur_q));

  a_r7_chain: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n |=> (cur_q[ADDR_W-1:SLICE_W] == $past(cur_q[ADDR_W-1:SLICE_W]))
             || ($past(cur_q[SLICE_W-1:0]) == {SLICE_W{1'b1}}));

  a_r8_word: assert property (@(posedge clk) disable iff (!rst_n)
    !word_oe_n |-> (addr_vld && addr_out == cur_q));

  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    word_oe_n |-> (!addr_vld && addr_out == '0));

  a_r9_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_oe_n && lo_oe_n) |-> (data_vld && data_out == cur_q[ADDR_W-1 -: DATA_W]));

  a_r10_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_oe_n && !lo_oe_n) |-> (data_vld && data_out == cur_q[DATA_W-1:0]));

  a_r11_one_src: assert property (@(posedge clk) disable iff (!rst_n)
    data_vld |-> $countones({hi_oe_n, lo_oe_n}) == 1);

  a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
    !data_vld |-> data_out == '0);

endmodule

bind fetch_addr_counter fetch_addr_counter_chk #(
  .ADDR_W  (ADDR_W),
  .SLICE_W (SLICE_W),
  .DATA_W  (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_n      (wr_n),
  .cnt_en    (cnt_en),
  .addr_in   (addr_in),
  .word_oe_n (word_oe_n),
  .hi_oe_n   (hi_oe_n),
  .lo_oe_n   (lo_oe_n),
  .addr_out  (addr_out),
  .addr_vld  (addr_vld),
  .data_out  (data_out),
  .data_vld  (data_vld),
  .cur_q     (pc_q)
);

// File: tb/fetch_addr_counter_tb.sv
`timescale 1ns/1ps
module fetch_addr_counter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_n = 1'b1;
  logic        cnt_en = 1'b0;
  logic [15:0] addr_in = '0;
  logic        word_oe_n = 1'b1;
  logic        hi_oe_n = 1'b1;
  logic        lo_oe_n = 1'b1;
  logic [15:0] addr_out;
  logic        addr_vld;
  logic [7:0]  data_out;
  logic        data_vld;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [15:0] model = '0;

  always #2.5 clk = ~clk;

  fetch_addr_counter u_dut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .cnt_en(cnt_en), .addr_in(addr_in),
    .word_oe_n(word_oe_n), .hi_oe_n(hi_oe_n), .lo_oe_n(lo_oe_n),
    .addr_out(addr_out), .addr_vld(addr_vld), .data_out(data_out), .data_vld(data_vld)
  );

  function automatic logic [15:0] next_val(logic [15:0] cur, logic w_n, logic c, logic [15:0] d);
    if (!w_n) return d;
    if (c) return cur + 16'd1;
    return cur;
  endfunction

  function automatic logic [8:0] exp_data(logic [15:0] v, logic h_n, logic l_n);
    if (!h_n && l_n) return {1'b1, v[15:8]};
    if (h_n && !l_n) return {1'b1, v[7:0]};
    return 9'd0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic verify(string tag);
    logic [8:0] ed;
    chk("R8 addr_vld", {31'd0, addr_vld}, {31'd0, ~word_oe_n});
    chk(word_oe_n ? "R8 released" : tag, {16'd0, addr_out}, {16'd0, word_oe_n ? 16'd0 : model});
    ed = exp_data(model, hi_oe_n, lo_oe_n);
    if (!hi_oe_n && lo_oe_n)      chk("R9 hi byte", {23'd0, data_vld, data_out}, {23'd0, ed});
    else if (hi_oe_n && !lo_oe_n) chk("R10 lo byte", {23'd0, data_vld, data_out}, {23'd0, ed});
    else                          chk("R11 released", {23'd0, data_vld, data_out}, {23'd0, ed});
  endtask

  task automatic step(logic w_n, logic c, logic [15:0] d, logic wo, logic ho, logic lo);
    string tg;
    @(negedge clk);
    wr_n = w_n; cnt_en = c; addr_in = d; word_oe_n = wo; hi_oe_n = ho; lo_oe_n = lo;
    if (!w_n)                      tg = c ? "R4 load over count" : "R2 load";
    else if (!c)                   tg = "R6 hold";
    else if (model == 16'hFFFF)    tg = "R5 wrap";
    else if (model[3:0] == 4'hF)   tg = "R7 carry chain";
    else                           tg = "R3 count";
    @(posedge clk);
    model = next_val(model, w_n, c, d);
    #1;
    verify(tg);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    logic [15:0] corners [5];
    corners[0] = 16'hFFFF; corners[1] = 16'h00FF; corners[2] = 16'h0FFF;
    corners[3] = 16'hFFFE; corners[4] = 16'h000F;
    seed_v = $urandom(32'd51423);

    // R1: value is zero during reset
    word_oe_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset value", {16'd0, addr_out}, 32'd0);
    chk("R1 reset valid", {31'd0, addr_vld}, 32'd1);
    @(negedge clk); rst_n = 1'b1;

    // Directed corners
    step(1'b0, 1'b0, 16'hFFFF, 1'b0, 1'b1, 1'b1);   // R2
    step(1'b1, 1'b1, 16'h1234, 1'b0, 1'b0, 1'b1);   // R5 wrap to zero
    step(1'b0, 1'b0, 16'h00FF, 1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b1);   // R7 -> 0x0100
    step(1'b0, 1'b0, 16'h0FFF, 1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b1);   // R7 -> 0x1000
    step(1'b0, 1'b0, 16'h000F, 1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b1, 16'h0000, 1'b0, 1'b1, 1'b0);   // R7 -> 0x0010
    step(1'b0, 1'b1, 16'hA5C3, 1'b0, 1'b1, 1'b1);   // R4 load wins
    step(1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0);   // R6 hold, R11 clash
    step(1'b1, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1);   // R8 released, R9

    // R1: asynchronous clear between clock edges
    step(1'b0, 1'b0, 16'h7E81, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    wr_n = 1'b1; cnt_en = 1'b0;
    #0.5 rst_n = 1'b0;
    #0.5;
    model = '0;
    chk("R1 async clear", {16'd0, addr_out}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic w_n, c, wo, ho, lo;
      logic [15:0] d;
      w_n = ($urandom % 6) != 0;
      c   = ($urandom % 4) != 0;
      d   = (($urandom % 2) == 0) ? corners[$urandom % 5] : 16'($urandom);
      wo  = ($urandom % 4) == 0;
      ho  = ($urandom % 2) == 0;
      lo  = ($urandom % 2) == 0;
      step(w_n, c, d, wo, ho, lo);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule